// File: doc/BRIEF.md
# Context-Tagged Translation Cache with Global Entries

This block is a small, fully associative cache of address translations. Each slot remembers a virtual page number, the frame it maps to, three permission bits, a global flag and a 12-bit context tag. A requester presents a virtual page and receives, one cycle later, a hit indication with the frame and permissions. The current context lives in a register inside the block. A slot answers a lookup when its page matches and it is either global or tagged with that current context.

Fills arrive as a raw 64-bit page table entry plus the virtual page. The block extracts the frame, the permissions and the global flag, and tags the new slot with the current context. There is also a single-page invalidate, used before a frame is handed out again. A context-switch port loads a new current context. The switch can be plain, so that the old context's slots stay resident, or it can request a flush, which drops every non-global slot and keeps the global ones.

Top module: `ctx_tlb`

## Requirements
- R1: After reset every slot is invalid, the current context is zero, and a lookup misses.
- R2: `resp_valid` is high exactly in the cycle after a cycle with `lk_req` high. On a miss, `lk_pfn` and `lk_perm` read zero.
- R3: A lookup hits when a valid slot has the same virtual page and that slot is global or its tag equals the current context.
- R4: A fill takes the frame from `fill_pte[12 +: PFN_W]` and the global flag from `fill_pte[8]`. It takes the permissions as `{fill_pte[63] no-execute, fill_pte[2] user, fill_pte[1] writable}` and tags the slot with the current context.
- R5: A fill with no matching slot goes to the lowest-numbered invalid slot. When every slot is valid, it replaces the slot named by a round-robin pointer that starts at 0 after reset and advances by one for each such replacement.
- R6: A fill that matches an existing slot (same page, and that slot global or tagged with the current context) overwrites that slot instead of adding a second one.
- R7: A switch without flush loads `sw_ctx` into the current context and leaves every slot untouched, so slots of the earlier context hit again after switching back.
- R8: A switch with flush invalidates every non-global slot and keeps every global slot.
- R9: A single-page invalidate clears the slots for that page that are tagged with the current context, and any global slot for that page. Slots for that page tagged with other contexts stay valid.
- R10: When several update requests share a cycle, the switch wins over the invalidate and the invalidate wins over the fill. The losing requests are dropped.
- R11: A lookup is answered from the state before the clock edge that samples it. A switch in the same cycle does not change that lookup's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Virtual page to translate |
| resp_valid | output | 1 | Lookup result valid (one cycle after request) |
| lk_hit | output | 1 | Lookup found a translation |
| lk_pfn | output | PFN_W | Translated frame number |
| lk_perm | output | 3 | {no-execute, user, writable} |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Virtual page being installed |
| fill_pte | input | 64 | Page table entry supplying frame, flags and permissions |
| inv_en | input | 1 | Invalidate one page |
| inv_vpn | input | VPN_W | Page to invalidate |
| sw_en | input | 1 | Context switch |
| sw_ctx | input | CTX_W | New current context |
| sw_flush | input | 1 | Drop non-global slots on this switch |

## Verification
The hardest situation to reach from the ports is replacement when every slot is full. In that situation both the round-robin pointer and the preference for invalid slots act in the same sequence. The stimulus fills four pages into a four-slot instance and adds two more to force two replacements. It then frees one slot with an invalidate and fills twice more. Lookups of every page show which slot each fill displaced. A second hard case is a global slot and a tagged slot for the same page that coexist. This case is reached by switching contexts without flushing between fills.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PTE_W          = 64;
  localparam int PTE_GLOBAL_BIT = 8;
  localparam int PTE_PFN_LSB    = 12;
  localparam int PTE_WR_BIT     = 1;
  localparam int PTE_USR_BIT    = 2;
  localparam int PTE_NX_BIT     = 63;
  localparam int PERM_W         = 3;

  // Permission triple {no-execute, user, writable} pulled from an entry.
  function automatic logic [PERM_W-1:0] perm_of(input logic [PTE_W-1:0] pte);
    return {pte[PTE_NX_BIT], pte[PTE_USR_BIT], pte[PTE_WR_BIT]};
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N     = 8,
  parameter int VPN_W = 27,
  parameter int CTX_W = 12
) (
  input  logic [N-1:0]            slot_valid,
  input  logic [N-1:0][VPN_W-1:0] slot_vpn,
  input  logic [N-1:0]            slot_glob,
  input  logic [N-1:0][CTX_W-1:0] slot_tag,
  input  logic [VPN_W-1:0]        q_vpn,
  input  logic [CTX_W-1:0]        q_ctx,
  output logic [N-1:0]            match
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = slot_valid[i] && (slot_vpn[i] == q_vpn) &&
                      (slot_glob[i] || (slot_tag[i] == q_ctx));
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     slot_valid,
  input  logic             advance,
  output logic [IDX_W-1:0] victim_idx,
  output logic             full
);
  logic [IDX_W-1:0] rr_q;

  assign full = &slot_valid;

  always_comb begin
    victim_idx = rr_q;
    for (int i = N - 1; i >= 0; i--) begin
      if (!slot_valid[i]) victim_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rr_q <= '0;
    else if (advance) rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/ctx_tlb.sv
module ctx_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 27,
  parameter int PFN_W   = 28,
  parameter int CTX_W   = 12,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_req,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              resp_valid,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PTE_W-1:0]  fill_pte,
  input  logic              inv_en,
  input  logic [VPN_W-1:0]  inv_vpn,
  input  logic              sw_en,
  input  logic [CTX_W-1:0]  sw_ctx,
  input  logic              sw_flush
);
  // Slot state
  logic [ENTRIES-1:0]                valid_q;
  logic [ENTRIES-1:0]                glob_q;
  logic [ENTRIES-1:0][VPN_W-1:0]     vpn_q;
  logic [ENTRIES-1:0][CTX_W-1:0]     tag_q;
  logic [ENTRIES-1:0][PFN_W-1:0]     pfn_q;
  logic [ENTRIES-1:0][PERM_W-1:0]    perm_q;
  logic [CTX_W-1:0]                  cur_ctx_q;

  // Named internal events
  logic sw_fire, inv_fire, fill_fire;
  logic [ENTRIES-1:0] lk_match, inv_match, fill_match;
  logic fill_hit_any, full;
  logic [IDX_W-1:0] victim_idx, fill_slot, lk_slot;

  assign sw_fire      = sw_en;
  assign inv_fire     = inv_en && !sw_en;
  assign fill_fire    = fill_en && !sw_en && !inv_en;
  assign fill_hit_any = |fill_match;

  logic pte_unused;
  assign pte_unused = ^{fill_pte[PTE_W-2:PTE_PFN_LSB+PFN_W], fill_pte[11:9],
                        fill_pte[7:3], fill_pte[0]};

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W)) i_lk_match (
    .slot_valid(valid_q), .slot_vpn(vpn_q), .slot_glob(glob_q), .slot_tag(tag_q),
    .q_vpn(lk_vpn), .q_ctx(cur_ctx_q), .match(lk_match));

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W)) i_inv_match (
    .slot_valid(valid_q), .slot_vpn(vpn_q), .slot_glob(glob_q), .slot_tag(tag_q),
    .q_vpn(inv_vpn), .q_ctx(cur_ctx_q), .match(inv_match));

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .CTX_W(CTX_W)) i_fill_match (
    .slot_valid(valid_q), .slot_vpn(vpn_q), .slot_glob(glob_q), .slot_tag(tag_q),
    .q_vpn(fill_vpn), .q_ctx(cur_ctx_q), .match(fill_match));

  tlb_victim #(.N(ENTRIES)) i_victim (
    .clk(clk), .rst_n(rst_n), .slot_valid(valid_q),
    .advance(fill_fire && !fill_hit_any && full),
    .victim_idx(victim_idx), .full(full));

  // Lowest matching slot for fill overwrite and for lookup.
  always_comb begin
    fill_slot = victim_idx;
    lk_slot   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fill_match[i]) fill_slot = IDX_W'(i);
      if (lk_match[i])   lk_slot   = IDX_W'(i);
    end
  end

  // Valid bits and current context
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= '0;
      cur_ctx_q <= '0;
    end else if (sw_fire) begin
      cur_ctx_q <= sw_ctx;
      if (sw_flush) valid_q <= valid_q & glob_q;
    end else if (inv_fire) begin
      valid_q <= valid_q & ~inv_match;
    end else if (fill_fire) begin
      valid_q[fill_slot] <= 1'b1;
    end
  end

  // Slot payload, written only by fills
  always_ff @(posedge clk) begin
    if (rst_n && fill_fire) begin
      vpn_q[fill_slot]  <= fill_vpn;
      tag_q[fill_slot]  <= cur_ctx_q;
      glob_q[fill_slot] <= fill_pte[PTE_GLOBAL_BIT];
      pfn_q[fill_slot]  <= fill_pte[PTE_PFN_LSB +: PFN_W];
      perm_q[fill_slot] <= perm_of(fill_pte);
    end
  end

  // Registered lookup response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      lk_hit     <= 1'b0;
      lk_pfn     <= '0;
      lk_perm    <= '0;
    end else begin
      resp_valid <= lk_req;
      lk_hit     <= lk_req && (|lk_match);
      lk_pfn     <= (lk_req && (|lk_match)) ? pfn_q[lk_slot]  : '0;
      lk_perm    <= (lk_req && (|lk_match)) ? perm_q[lk_slot] : '0;
    end
  end
endmodule

// File: rtl/ctx_tlb_sva.sv
module ctx_tlb_sva #(
  parameter int ENTRIES = 8,
  parameter int PFN_W   = 28,
  parameter int CTX_W   = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_req,
  input logic               resp_valid,
  input logic               lk_hit,
  input logic [PFN_W-1:0]   lk_pfn,
  input logic [2:0]         lk_perm,
  input logic               sw_en,
  input logic               sw_flush,
  input logic [CTX_W-1:0]   sw_ctx,
  input logic               inv_fire,
  input logic               fill_fire,
  input logic               fill_hit_any,
  input logic               full,
  input logic [ENTRIES-1:0] inv_match,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] glob_q,
  input logic [CTX_W-1:0]   cur_ctx_q
);
  assert_resp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> resp_valid);
  assert_no_spurious_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !resp_valid);
  assert_miss_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !lk_hit) |-> (lk_pfn == '0 && lk_perm == '0));
  assert_switch_loads_ctx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |=> cur_ctx_q == $past(sw_ctx));
  assert_ctx_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> $stable(cur_ctx_q));
  assert_switch_keeps_slots_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && !sw_flush) |=> valid_q == $past(valid_q));
  assert_flush_keeps_global_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_en && sw_flush) |=> valid_q == ($past(valid_q) & $past(glob_q)));
  assert_inv_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_fire |=> (valid_q & $past(inv_match)) == '0);
  assert_overwrite_no_growth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && fill_hit_any) |=> $countones(valid_q) == $countones($past(valid_q)));
  assert_free_slot_used_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_fire && !fill_hit_any && !full) |=>
      $countones(valid_q) == $countones($past(valid_q)) + 1);
  assert_switch_blocks_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sw_en |-> (!inv_fire && !fill_fire));
endmodule

bind ctx_tlb ctx_tlb_sva #(.ENTRIES(ENTRIES), .PFN_W(PFN_W), .CTX_W(CTX_W)) i_sva (.*);

// File: tb/test_ctx_tlb.sv
module test_ctx_tlb;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 4;
  localparam int VPN_W = 20;
  localparam int PFN_W = 20;
  localparam int CTX_W = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic lk_req, fill_en, inv_en, sw_en, sw_flush;
  logic [VPN_W-1:0] lk_vpn, fill_vpn, inv_vpn;
  logic [63:0] fill_pte;
  logic [CTX_W-1:0] sw_ctx;
  logic resp_valid, lk_hit;
  logic [PFN_W-1:0] lk_pfn;
  logic [2:0] lk_perm;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [PFN_W+3:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_tlb #(.ENTRIES(N), .VPN_W(VPN_W), .PFN_W(PFN_W), .CTX_W(CTX_W)) i_ctx_tlb (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vpn(lk_vpn),
    .resp_valid(resp_valid), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_perm(lk_perm),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pte(fill_pte),
    .inv_en(inv_en), .inv_vpn(inv_vpn),
    .sw_en(sw_en), .sw_ctx(sw_ctx), .sw_flush(sw_flush));

  function automatic logic [63:0] mk_pte(input logic [PFN_W-1:0] pfn, input bit g,
                                         input bit nx, input bit u, input bit w);
    logic [63:0] p = '0;
    p[12 +: PFN_W] = pfn;
    p[8] = g; p[63] = nx; p[2] = u; p[1] = w; p[0] = 1'b1;
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic step();
    @(negedge clk);
    lk_req = 0; fill_en = 0; inv_en = 0; sw_en = 0; sw_flush = 0;
  endtask

  task automatic look_arm(input logic [VPN_W-1:0] v, input bit h,
                          input logic [PFN_W-1:0] pfn, input logic [2:0] perm,
                          input string req);
    lk_req = 1; lk_vpn = v;
    exp_q.push_back({h, pfn, perm});
    tag_q.push_back(req);
  endtask

  task automatic fill_arm(input logic [VPN_W-1:0] v, input logic [63:0] pte);
    fill_en = 1; fill_vpn = v; fill_pte = pte;
  endtask

  task automatic inv_arm(input logic [VPN_W-1:0] v);
    inv_en = 1; inv_vpn = v;
  endtask

  task automatic sw_arm(input logic [CTX_W-1:0] c, input bit f);
    sw_en = 1; sw_ctx = c; sw_flush = f;
  endtask

  task automatic look(input logic [VPN_W-1:0] v, input bit h,
                      input logic [PFN_W-1:0] pfn, input logic [2:0] perm,
                      input string req);
    look_arm(v, h, pfn, perm, req); step();
  endtask
  task automatic fill(input logic [VPN_W-1:0] v, input logic [63:0] pte);
    fill_arm(v, pte); step();
  endtask
  task automatic inval(input logic [VPN_W-1:0] v);
    inv_arm(v); step();
  endtask
  task automatic switch_ctx(input logic [CTX_W-1:0] c, input bit f);
    sw_arm(c, f); step();
  endtask

  // Monitor: pops expectations as responses emerge.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && resp_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(0, "R2", "response without request (act resp_valid=1, exp 0)");
      end else begin
        logic [PFN_W+3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({lk_hit, lk_pfn, lk_perm} === e, t,
              $sformatf("act hit=%0b pfn=%h perm=%b exp hit=%0b pfn=%h perm=%b",
                        lk_hit, lk_pfn, lk_perm, e[PFN_W+3], e[PFN_W+2:3], e[2:0]));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; lk_req = 0; fill_en = 0; inv_en = 0; sw_en = 0; sw_flush = 0;
    lk_vpn = '0; fill_vpn = '0; inv_vpn = '0; fill_pte = '0; sw_ctx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(resp_valid === 1'b0 && lk_hit === 1'b0, "R1",
          $sformatf("reset outputs act valid=%0b hit=%0b exp 0 0", resp_valid, lk_hit));
    look(20'h10, 0, '0, 3'b000, "R1 empty after reset");

    // Fill in context 0, then a global page
    fill(20'h10, mk_pte(20'h00111, 0, 0, 1, 1));
    look(20'h10, 1, 20'h00111, 3'b011, "R4 fields ctx0");
    fill(20'h20, mk_pte(20'h00222, 1, 1, 0, 0));
    look(20'h20, 1, 20'h00222, 3'b100, "R4 global nx");

    // Plain switch: tagged slot hidden, global visible
    switch_ctx(12'd5, 0);
    look(20'h10, 0, '0, 3'b000, "R3 other ctx miss");
    look(20'h20, 1, 20'h00222, 3'b100, "R3 global hit");
    fill(20'h10, mk_pte(20'h00333, 0, 0, 1, 0));
    look(20'h10, 1, 20'h00333, 3'b010, "R3 ctx5 slot");
    switch_ctx(12'd0, 0);
    look(20'h10, 1, 20'h00111, 3'b011, "R7 ctx0 retained");

    // Overwrite on matching fill
    fill(20'h10, mk_pte(20'h00444, 0, 0, 0, 1));
    look(20'h10, 1, 20'h00444, 3'b001, "R6 overwrite");

    // Single-page invalidate
    inval(20'h10);
    look(20'h10, 0, '0, 3'b000, "R9 ctx0 cleared");
    switch_ctx(12'd5, 0);
    look(20'h10, 1, 20'h00333, 3'b010, "R9 other ctx kept");
    inval(20'h20);
    look(20'h20, 0, '0, 3'b000, "R9 global cleared");

    // Flushing switch
    fill(20'h50, mk_pte(20'h00666, 1, 0, 0, 0));
    fill(20'h60, mk_pte(20'h00777, 0, 0, 1, 1));
    switch_ctx(12'd7, 1);
    look(20'h50, 1, 20'h00666, 3'b000, "R8 global kept");
    switch_ctx(12'd5, 0);
    look(20'h60, 0, '0, 3'b000, "R8 non-global gone");
    look(20'h10, 0, '0, 3'b000, "R8 older non-global gone");

    // Priority among same-cycle updates
    fill_arm(20'h70, mk_pte(20'h00aaa, 0, 0, 0, 0));
    sw_arm(12'd9, 0);
    step();
    look(20'h70, 0, '0, 3'b000, "R10 switch beats fill");
    fill_arm(20'h50, mk_pte(20'h00999, 1, 0, 0, 0));
    inv_arm(20'h50);
    step();
    look(20'h50, 0, '0, 3'b000, "R10 invalidate beats fill");

    // Lookup alongside a switch
    fill(20'h80, mk_pte(20'h00888, 0, 0, 1, 1));
    look_arm(20'h80, 1, 20'h00888, 3'b011, "R11 lookup uses old ctx");
    sw_arm(12'd2, 0);
    step();
    look(20'h80, 0, '0, 3'b000, "R11 new ctx after switch");

    // Replacement order on a full cache
    switch_ctx(12'd0, 1);
    for (int i = 0; i < 6; i++) fill(20'h100 + 20'(i), mk_pte(20'h00a00 + 20'(i), 0, 0, 0, 1));
    look(20'h100, 0, '0, 3'b000, "R5 first replacement took slot 0");
    look(20'h101, 0, '0, 3'b000, "R5 second replacement took slot 1");
    look(20'h102, 1, 20'h00a02, 3'b001, "R5 slot 2 kept");
    look(20'h104, 1, 20'h00a04, 3'b001, "R5 new page present");
    inval(20'h103);
    fill(20'h106, mk_pte(20'h00a06, 0, 0, 0, 1));
    look(20'h102, 1, 20'h00a02, 3'b001, "R5 free slot preferred");
    fill(20'h107, mk_pte(20'h00a07, 0, 0, 0, 1));
    look(20'h102, 0, '0, 3'b000, "R5 pointer moved to slot 2");
    look(20'h106, 1, 20'h00a06, 3'b001, "R5 slot 3 page");
    look(20'h105, 1, 20'h00a05, 3'b001, "R5 slot 1 page");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R2",
          $sformatf("pending responses act=%0d exp=0", exp_q.size()));
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule